// File: doc/BRIEF.md
# Multi-Unit Field-Operation Issue Controller

This block accepts field-arithmetic instructions from a host into an eight-entry instruction queue and hands them to a bank of parallel arithmetic units with fixed latency. Each instruction names up to four source registers and one destination register in a small coprocessor register file. A scoreboard keeps one pending-write bit per register. Each cycle the controller scans the queue from the oldest entry and issues the first instruction that has no hazard against in-flight work or against older queued work. A younger independent instruction can therefore overtake an older one that is stalled.

The queue scan acts as fetch and decode. At issue, the unit captures its operands and then counts an operand-read phase whose length depends on the operation type, followed by an execute phase. A single shared write-back port then retires one finished result per cycle, so results that finish together leave one at a time. The host sees a queue-full flag and a drop pulse for any push made while the queue is full. The arithmetic units are stand-ins: each computes a product in GF(2^8) with an added term and a fixed cycle count.

Top module: `fop_issue_ctrl`

## Requirements
- R1: After reset, q_full, push_drop and wb_valid are low and the queue is empty. Register i holds (37*i + 5) mod 256.
- R2: q_full is high exactly when 8 instructions are queued. A push made while q_full is high is discarded, and push_drop is high in that same cycle.
- R3: push_op = 0 computes dst = A*B + C. push_op = 1 computes dst = A*(B + D) + C. Here * is multiplication in GF(2^8) modulo x^8+x^4+x^3+x+1 and + is bitwise XOR. Operand A, B, C, D are the registers named by push_src_a, push_src_b, push_src_c and push_src_d, and D is read only when push_op = 1.
- R4: When the queue is empty and a unit is free, an instruction pushed at clock edge E shows its write-back (wb_valid high) in the cycle after edge E+8 for push_op = 0 and after edge E+9 for push_op = 1. The read phase lasts 3 or 4 cycles and the execute phase lasts 4 cycles.
- R5: An instruction never reads a register that an older instruction has yet to write. Every result equals the value from in-order sequential execution.
- R6: A younger instruction with no hazard issues ahead of an older instruction stalled on a read-after-write dependency.
- R7: Writes to the same register retire in program order. An instruction does not write a register that an older, not yet issued instruction still reads.
- R8: At most one result is written back per cycle. When several units finish together, the lowest unit index retires first, and the others follow in later cycles.
- R9: At most one instruction issues per cycle, into the lowest-numbered free unit. With all 4 units busy, further instructions wait until a unit has written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Host offers an instruction this cycle |
| push_op | input | 1 | Operation: 0 = A*B+C, 1 = A*(B+D)+C |
| push_src_a | input | 3 | Source register A |
| push_src_b | input | 3 | Source register B |
| push_src_c | input | 3 | Source register C |
| push_src_d | input | 3 | Source register D (operation 1 only) |
| push_dst | input | 3 | Destination register |
| q_full | output | 1 | Instruction queue holds 8 entries |
| push_drop | output | 1 | Current push is discarded because the queue is full |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_unit | output | 2 | Index of the unit retiring |
| wb_reg | output | 3 | Register being written |
| wb_data | output | 8 | Value being written |

## Verification
A scoreboard bit that is set or cleared at the wrong time shows up at the write-back port. Either a wb_data value departs from the in-order result at the very first write to an affected register, or a dependent instruction waits forever and the count of retired results stops short of the count of accepted ones. A fault in the queue shift or in the pick logic appears as a wrong value, a missing write-back or a retirement in the wrong order, within the latency of one instruction. A fault in the timing counts or in the arbitration appears as a write-back that comes in the wrong cycle or from the wrong unit, visible in the first isolated or simultaneous completion.

// File: rtl/fop_issue_pkg.sv
package fop_issue_pkg;

  typedef enum logic {
    FOP_MAC     = 1'b0,
    FOP_MAC_SUM = 1'b1
  } fop_e;

  function automatic logic needs_d(fop_e op);
    return op == FOP_MAC_SUM;
  endfunction

  function automatic int busy_cycles(fop_e op, int rd_short, int rd_long, int ex);
    return ((op == FOP_MAC_SUM) ? rd_long : rd_short) + ex;
  endfunction

  function automatic logic touches_src(fop_e op, int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d, int unsigned r);
    return (a == r) || (b == r) || (c == r) || (needs_d(op) && (d == r));
  endfunction

endpackage

// File: rtl/fop_queue.sv
module fop_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          push_op,
  input  logic [AW-1:0] push_a,
  input  logic [AW-1:0] push_b,
  input  logic [AW-1:0] push_c,
  input  logic [AW-1:0] push_d,
  input  logic [AW-1:0] push_dst,
  input  logic          pop_en,
  input  logic [IW-1:0] pop_idx,
  output logic [CW-1:0] count,
  output logic          e_op  [DEPTH],
  output logic [AW-1:0] e_a   [DEPTH],
  output logic [AW-1:0] e_b   [DEPTH],
  output logic [AW-1:0] e_c   [DEPTH],
  output logic [AW-1:0] e_d   [DEPTH],
  output logic [AW-1:0] e_dst [DEPTH]
);

  logic [CW-1:0] wr_slot;

  always_comb wr_slot = count - CW'(pop_en);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + CW'(push_en) - CW'(pop_en);
  end

  // Removal closes the gap by shifting younger entries down; a push lands after them.
  always_ff @(posedge clk) begin
    if (pop_en) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(pop_idx)) begin
          e_op[i]  <= e_op[i+1];
          e_a[i]   <= e_a[i+1];
          e_b[i]   <= e_b[i+1];
          e_c[i]   <= e_c[i+1];
          e_d[i]   <= e_d[i+1];
          e_dst[i] <= e_dst[i+1];
        end
      end
    end
    if (push_en) begin
      e_op[IW'(wr_slot)]  <= push_op;
      e_a[IW'(wr_slot)]   <= push_a;
      e_b[IW'(wr_slot)]   <= push_b;
      e_c[IW'(wr_slot)]   <= push_c;
      e_d[IW'(wr_slot)]   <= push_d;
      e_dst[IW'(wr_slot)] <= push_dst;
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  p_pop_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (int'(pop_idx) < int'(count)));

endmodule

// File: rtl/fop_pick.sv
module fop_pick
  import fop_issue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AW     = 3,
  parameter int NREG   = 8,
  parameter int NUNITS = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int UW    = (NUNITS > 1) ? $clog2(NUNITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   count,
  input  logic            e_op  [DEPTH],
  input  logic [AW-1:0]   e_a   [DEPTH],
  input  logic [AW-1:0]   e_b   [DEPTH],
  input  logic [AW-1:0]   e_c   [DEPTH],
  input  logic [AW-1:0]   e_d   [DEPTH],
  input  logic [AW-1:0]   e_dst [DEPTH],
  input  logic [NREG-1:0] pend,
  input  logic [NUNITS-1:0] unit_busy,
  output logic            fire,
  output logic [IW-1:0]   pick_idx,
  output logic [UW-1:0]   pick_unit
);

  logic ready [DEPTH];
  logic found_entry, found_unit;

  // Hazard screen: against the scoreboard and against every older queued entry.
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      ready[j] = (j < int'(count));
      if (pend[e_a[j]] || pend[e_b[j]] || pend[e_c[j]] || pend[e_dst[j]] ||
          (needs_d(fop_e'(e_op[j])) && pend[e_d[j]]))
        ready[j] = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (i < j) begin
          if (touches_src(fop_e'(e_op[j]), e_a[j], e_b[j], e_c[j], e_d[j], e_dst[i]) ||
              (e_dst[i] == e_dst[j]) ||
              touches_src(fop_e'(e_op[i]), e_a[i], e_b[i], e_c[i], e_d[i], e_dst[j]))
            ready[j] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    found_entry = 1'b0;
    pick_idx    = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (ready[j] && !found_entry) begin
        found_entry = 1'b1;
        pick_idx    = IW'(j);
      end
    end
    found_unit = 1'b0;
    pick_unit  = '0;
    for (int u = 0; u < NUNITS; u++) begin
      if (!unit_busy[u] && !found_unit) begin
        found_unit = 1'b1;
        pick_unit  = UW'(u);
      end
    end
    fire = found_entry && found_unit;
  end

  p_issue_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !pend[e_dst[pick_idx]] && !pend[e_a[pick_idx]] && !pend[e_b[pick_idx]]
             && !pend[e_c[pick_idx]]);

endmodule

// File: rtl/fop_unit.sv
module fop_unit
  import fop_issue_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          AW     = 3,
  parameter logic [DW-1:0] POLY = 8'h1B,
  parameter int          RD_SHORT = 3,
  parameter int          RD_LONG  = 4,
  parameter int          EX_CYC   = 4,
  localparam int         TW = $clog2(RD_LONG + EX_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op,
  input  logic [DW-1:0] va,
  input  logic [DW-1:0] vb,
  input  logic [DW-1:0] vc,
  input  logic [DW-1:0] vd,
  input  logic [AW-1:0] dst,
  input  logic          grant,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res,
  output logic [AW-1:0] res_dst
);

  logic [TW-1:0] timer;

  function automatic logic [DW-1:0] gf_mul(logic [DW-1:0] x, logic [DW-1:0] y);
    logic [DW-1:0] acc;
    logic [DW-1:0] sh;
    acc = '0;
    sh  = x;
    for (int k = 0; k < DW; k++) begin
      if (y[k]) acc = acc ^ sh;
      sh = sh[DW-1] ? ((sh << 1) ^ POLY) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [DW-1:0] field_op(logic o, logic [DW-1:0] a, logic [DW-1:0] b,
                                             logic [DW-1:0] c, logic [DW-1:0] d);
    return gf_mul(a, needs_d(fop_e'(o)) ? (b ^ d) : b) ^ c;
  endfunction

  assign done = busy && (timer == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      timer <= TW'(busy_cycles(fop_e'(op), RD_SHORT, RD_LONG, EX_CYC));
    end else if (grant) begin
      busy  <= 1'b0;
    end else if (busy && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      res     <= field_op(op, va, vb, vc, vd);
      res_dst <= dst;
    end
  end

  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_grant_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> done);

endmodule

// File: rtl/fop_issue_ctrl.sv
module fop_issue_ctrl
  import fop_issue_pkg::*;
#(
  parameter int            QDEPTH    = 8,
  parameter int            NUM_REGS  = 8,
  parameter int            NUM_UNITS = 4,
  parameter int            DW        = 8,
  parameter logic [DW-1:0] POLY      = 8'h1B,
  parameter int            RD_SHORT  = 3,
  parameter int            RD_LONG   = 4,
  parameter int            EX_CYC    = 4,
  localparam int           AW = $clog2(NUM_REGS),
  localparam int           UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic          push_op,
  input  logic [AW-1:0] push_src_a,
  input  logic [AW-1:0] push_src_b,
  input  logic [AW-1:0] push_src_c,
  input  logic [AW-1:0] push_src_d,
  input  logic [AW-1:0] push_dst,
  output logic          q_full,
  output logic          push_drop,
  output logic          wb_valid,
  output logic [UW-1:0] wb_unit,
  output logic [AW-1:0] wb_reg,
  output logic [DW-1:0] wb_data
);

  localparam int CW = $clog2(QDEPTH + 1);
  localparam int IW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [CW-1:0] q_count;
  logic          q_op  [QDEPTH];
  logic [AW-1:0] q_a   [QDEPTH];
  logic [AW-1:0] q_b   [QDEPTH];
  logic [AW-1:0] q_c   [QDEPTH];
  logic [AW-1:0] q_d   [QDEPTH];
  logic [AW-1:0] q_dst [QDEPTH];

  logic [DW-1:0]       regs [NUM_REGS];
  logic [NUM_REGS-1:0] pend;

  logic                 issue_fire;
  logic [IW-1:0]        issue_idx;
  logic [UW-1:0]        issue_unit;
  logic                 push_take;
  logic [NUM_UNITS-1:0] u_busy, u_done, u_grant, u_start;
  logic [DW-1:0]        u_res [NUM_UNITS];
  logic [AW-1:0]        u_dst [NUM_UNITS];

  function automatic logic [DW-1:0] reset_value(int i);
    return DW'(i * 37 + 5);
  endfunction

  assign q_full    = (int'(q_count) == QDEPTH);
  assign push_drop = push_valid && q_full;
  assign push_take = push_valid && !q_full;

  fop_queue #(.DEPTH(QDEPTH), .AW(AW)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_en(push_take), .push_op(push_op),
    .push_a(push_src_a), .push_b(push_src_b), .push_c(push_src_c),
    .push_d(push_src_d), .push_dst(push_dst),
    .pop_en(issue_fire), .pop_idx(issue_idx), .count(q_count),
    .e_op(q_op), .e_a(q_a), .e_b(q_b), .e_c(q_c), .e_d(q_d), .e_dst(q_dst)
  );

  fop_pick #(.DEPTH(QDEPTH), .AW(AW), .NREG(NUM_REGS), .NUNITS(NUM_UNITS)) u_pick (
    .clk(clk), .rst_n(rst_n), .count(q_count),
    .e_op(q_op), .e_a(q_a), .e_b(q_b), .e_c(q_c), .e_d(q_d), .e_dst(q_dst),
    .pend(pend), .unit_busy(u_busy),
    .fire(issue_fire), .pick_idx(issue_idx), .pick_unit(issue_unit)
  );

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    assign u_start[g] = issue_fire && (issue_unit == UW'(g));
    fop_unit #(.DW(DW), .AW(AW), .POLY(POLY), .RD_SHORT(RD_SHORT),
               .RD_LONG(RD_LONG), .EX_CYC(EX_CYC)) u_fu (
      .clk(clk), .rst_n(rst_n), .start(u_start[g]), .op(q_op[issue_idx]),
      .va(regs[q_a[issue_idx]]), .vb(regs[q_b[issue_idx]]),
      .vc(regs[q_c[issue_idx]]), .vd(regs[q_d[issue_idx]]),
      .dst(q_dst[issue_idx]), .grant(u_grant[g]),
      .busy(u_busy[g]), .done(u_done[g]), .res(u_res[g]), .res_dst(u_dst[g])
    );
  end

  // Shared write-back port: fixed priority toward the lowest unit index.
  always_comb begin
    u_grant  = '0;
    wb_valid = 1'b0;
    wb_unit  = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (u_done[u] && !wb_valid) begin
        wb_valid   = 1'b1;
        wb_unit    = UW'(u);
        u_grant[u] = 1'b1;
      end
    end
  end

  assign wb_reg  = u_dst[wb_unit];
  assign wb_data = u_res[wb_unit];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_value(i);
    end else begin
      if (wb_valid) begin
        regs[wb_reg] <= wb_data;
        pend[wb_reg] <= 1'b0;
      end
      if (issue_fire) pend[q_dst[issue_idx]] <= 1'b1;
    end
  end

  p_wb_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(u_grant));
  p_wb_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> pend[wb_reg]);
  p_drop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && q_full) |=> (q_count <= $past(q_count)));

endmodule

// File: tb/fop_issue_ctrl_tb.sv
module fop_issue_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 8;
  localparam int SLOTS      = 512;
  localparam int LIMIT      = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic       push_op = 1'b0;
  logic [2:0] push_src_a = '0, push_src_b = '0, push_src_c = '0, push_src_d = '0, push_dst = '0;
  logic       q_full, push_drop, wb_valid;
  logic [1:0] wb_unit;
  logic [2:0] wb_reg;
  logic [7:0] wb_data;

  fop_issue_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_op(push_op),
    .push_src_a(push_src_a), .push_src_b(push_src_b), .push_src_c(push_src_c),
    .push_src_d(push_src_d), .push_dst(push_dst),
    .q_full(q_full), .push_drop(push_drop), .wb_valid(wb_valid),
    .wb_unit(wb_unit), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int acc_n = 0, wb_n = 0;
  logic [7:0] refreg  [NREG];
  logic [7:0] seen    [NREG];
  logic [7:0] exp_tab [NREG][SLOTS];
  int exp_head [NREG];
  int exp_tail [NREG];
  int log_reg [4096];
  int log_unit [4096];
  int log_cyc [4096];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Field product by full carry-less multiply, then reduction from the top bit down.
  function automatic logic [7:0] ref_mul(logic [7:0] x, logic [7:0] y);
    logic [15:0] p;
    p = '0;
    for (int k = 0; k < 8; k++) if (y[k]) p = p ^ (16'(x) << k);
    for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (16'h011B << (k - 8));
    return p[7:0];
  endfunction

  // Write-back monitor: each result must equal the in-order value for that register (R3 R5 R7).
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      if (exp_head[wb_reg] == exp_tail[wb_reg]) begin
        chk(1'b0, "R5", "unexpected write-back to reg", int'(wb_reg), -1);
      end else begin
        chk(wb_data == exp_tab[wb_reg][exp_head[wb_reg] % SLOTS], "R3 R5 R7",
            "write-back value", int'(wb_data), int'(exp_tab[wb_reg][exp_head[wb_reg] % SLOTS]));
        exp_head[wb_reg] = exp_head[wb_reg] + 1;
      end
      seen[wb_reg] = wb_data;
      log_reg[wb_n % 4096]  = int'(wb_reg);
      log_unit[wb_n % 4096] = int'(wb_unit);
      log_cyc[wb_n % 4096]  = cyc;
      wb_n++;
    end
  end

  always @(negedge clk) begin
    if (cyc == LIMIT) begin
      chk(1'b0, "R5", "watchdog expired, results retired", wb_n, acc_n);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Returns the edge count at which the push was sampled; accepted is low if q_full was high.
  task automatic do_push(input bit op, input int a, input int b, input int c, input int d,
                         input int dst, output bit accepted, output int edge_no);
    logic [7:0] r;
    @(negedge clk);
    push_valid = 1'b1; push_op = op;
    push_src_a = 3'(a); push_src_b = 3'(b); push_src_c = 3'(c);
    push_src_d = 3'(d); push_dst = 3'(dst);
    accepted = !q_full;
    if (accepted) begin
      r = ref_mul(refreg[a], op ? (refreg[b] ^ refreg[d]) : refreg[b]) ^ refreg[c];
      refreg[dst] = r;
      exp_tab[dst][exp_tail[dst] % SLOTS] = r;
      exp_tail[dst]++;
      acc_n++;
    end
    @(posedge clk);
    #1;
    edge_no = cyc;
    push_valid = 1'b0;
  endtask

  task automatic drain();
    while (wb_n != acc_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit ok;
    int e0, e1, base, wcyc;
    for (int i = 0; i < NREG; i++) begin
      refreg[i] = 8'(i * 37 + 5);
      seen[i] = refreg[i];
      exp_head[i] = 0;
      exp_tail[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(q_full == 1'b0, "R1", "q_full after reset", int'(q_full), 0);
    chk(push_drop == 1'b0, "R1", "push_drop after reset", int'(push_drop), 0);
    chk(wb_valid == 1'b0, "R1", "wb_valid after reset", int'(wb_valid), 0);

    // R4: isolated latency for each operation type.
    base = wb_n;
    do_push(1'b0, 1, 2, 3, 0, 4, ok, e0);
    drain();
    chk(log_cyc[base % 4096] == e0 + 8, "R4", "op0 write-back cycle", log_cyc[base % 4096], e0 + 8);
    base = wb_n;
    do_push(1'b1, 5, 6, 7, 1, 2, ok, e0);
    drain();
    chk(log_cyc[base % 4096] == e0 + 9, "R4", "op1 write-back cycle", log_cyc[base % 4096], e0 + 9);

    // R6: younger independent instruction overtakes a stalled reader.
    base = wb_n;
    do_push(1'b1, 2, 3, 4, 5, 1, ok, e0);
    do_push(1'b0, 1, 0, 7, 0, 2, ok, e1);
    do_push(1'b0, 3, 4, 5, 0, 6, ok, e1);
    drain();
    chk(log_reg[base % 4096] == 1, "R6", "first retired reg", log_reg[base % 4096], 1);
    chk(log_reg[(base + 1) % 4096] == 6, "R6", "second retired reg (overtaker)", log_reg[(base + 1) % 4096], 6);
    chk(log_reg[(base + 2) % 4096] == 2, "R6", "third retired reg (stalled reader)", log_reg[(base + 2) % 4096], 2);

    // R8: two units finish in the same cycle; unit 0 retires first, unit 1 next cycle.
    base = wb_n;
    do_push(1'b1, 0, 3, 4, 5, 1, ok, e0);
    do_push(1'b0, 5, 6, 7, 0, 2, ok, e1);
    drain();
    chk(log_unit[base % 4096] == 0 && log_cyc[base % 4096] == e0 + 9, "R8",
        "first of simultaneous pair unit", log_unit[base % 4096], 0);
    chk(log_unit[(base + 1) % 4096] == 1 && log_cyc[(base + 1) % 4096] == e0 + 10, "R8",
        "second of simultaneous pair cycle", log_cyc[(base + 1) % 4096], e0 + 10);

    // R9: five independent instructions; the fifth waits for unit 0 to write back.
    base = wb_n;
    for (int k = 0; k < 5; k++) do_push(1'b0, 5, 6, 7, 0, k, ok, e0);
    drain();
    for (int k = 0; k < 4; k++)
      chk(log_unit[(base + k) % 4096] == k, "R9", "unit allocation", log_unit[(base + k) % 4096], k);
    wcyc = log_cyc[(base + 4) % 4096];
    chk(wcyc == e0 + 13, "R9", "fifth instruction write-back cycle", wcyc, e0 + 13);
    chk(log_unit[(base + 4) % 4096] == 0, "R9", "fifth instruction unit", log_unit[(base + 4) % 4096], 0);

    // R2: fill the queue behind a long producer, then push once more.
    do_push(1'b1, 1, 2, 3, 4, 0, ok, e0);
    for (int k = 0; k < 8; k++) do_push(1'b0, 0, 1, 2, 0, 1 + (k % 7), ok, e1);
    @(negedge clk);
    chk(q_full == 1'b1, "R2", "q_full with 8 queued", int'(q_full), 1);
    push_valid = 1'b1; push_op = 1'b0; push_src_a = 3'd0; push_dst = 3'd7;
    #1;
    chk(push_drop == 1'b1, "R2", "push_drop on push while full", int'(push_drop), 1);
    @(posedge clk);
    #1 push_valid = 1'b0;
    drain();
    chk(q_full == 1'b0, "R2", "q_full after drain", int'(q_full), 0);

    // R5 R7: random streams compared against sequential execution.
    for (int n = 0; n < 300; n++) begin
      ok = 1'b0;
      while (!ok)
        do_push(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                ok, e0);
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 6)) @(negedge clk);
    end
    drain();
    chk(wb_n == acc_n, "R5", "retired count", wb_n, acc_n);
    for (int i = 0; i < NREG; i++)
      chk(seen[i] == refreg[i], "R5 R7", "final register value", int'(seen[i]), int'(refreg[i]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule